// File: doc/BRIEF.md
# Seconds Timer with Alarm

This block is a free-running seconds timer that sits behind a simple 32-bit memory-mapped register bus. A programmable prescaler counts enable pulses from a slow clock. Each time it completes a full period it issues an increment, and that increment advances a 32-bit up-counter. Programming the prescaler to the slow-clock frequency makes the counter count seconds. Software can read the counter but cannot load it. It can only restart it, and a restart clears both the counter and the prescaler phase.

A 32-bit alarm compare register is checked on every increment. When the new counter value equals the alarm value, the alarm flag is set. The all-ones alarm value means no alarm. Each increment also sets an increment flag. Both flags are sticky and clear when the status register is read. Each flag can be enabled onto a single level interrupt by an enable bit that sits sixteen positions above it in the mode register.

The prescaler is a two-state machine. STALL is the reset state: the prescaler phase is held at zero and no increment is produced. RUN counts slow ticks. The transition STALL to RUN is taken on the clock after the prescaler field becomes non-zero. The transition RUN to STALL is taken on the clock after the field becomes zero.

Top module: `sectmr_top`

## Requirements
- R1: After reset the mode register (offset 0x00) reads 0x00008000, the alarm register (0x04) reads 0xFFFFFFFF, the counter (0x08) reads 0, status (0x0C) reads 0, and `irq` is low.
- R2: With the prescaler field (mode bits 15:0) set to N, where N is 1 or more, the counter advances by one on every Nth slow-tick pulse since the last restart. Clock cycles without a slow-tick pulse do not advance the counter or the prescaler phase.
- R3: With the prescaler field at 0, the timer stays in STALL and the counter does not advance, whatever slow-tick pulses arrive.
- R4: Writing mode with bit 18 set clears the counter and the prescaler phase in that write cycle. Bit 18 always reads back as 0. The write still stores the prescaler field (bits 15:0) and the enables (bits 17:16).
- R5: The counter register (0x08) and the status register (0x0C) have no write path, so writes to them leave their contents unchanged.
- R6: The alarm register is read/write over all 32 bits. Status bit 0 is set on the increment whose new counter value equals the alarm value, and never while the alarm holds 0xFFFFFFFF.
- R7: Status bit 1 is set on every counter increment.
- R8: Reading status returns the flags and clears them. A flag that is set in the same cycle as the read survives the read.
- R9: `irq` is high exactly when some status bit i is set and mode bit 16+i is set.
- R10: Reads of any other address, including unaligned offsets and offsets of 0x10 and above, return 0. Writes to such addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | One-cycle enable per slow-clock period |
| bus_en | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read strobe, 0 otherwise |
| irq | output | 1 | Level interrupt |

## Verification
The counter is read after every single slow tick for prescaler values 1 through 5. The arithmetic expectation (ticks divided by N) separates an off-by-one wrap from a correct one and shows whether the phase is really cleared on restart. A sparse tick stream with idle cycles between pulses shows that only pulses are counted, and a zero prescaler shows the STALL state. The alarm is approached one tick at a time so that firing before, at or after the match can be told apart. The enables are toggled one at a time to separate each interrupt term. A status read is issued in the same cycle as an increment to expose a clear that wins over a set.

// File: rtl/sectmr_pkg.sv
package sectmr_pkg;
    localparam int unsigned DATA_W      = 32;
    localparam int unsigned OFS_MODE    = 'h00;
    localparam int unsigned OFS_ALARM   = 'h04;
    localparam int unsigned OFS_VALUE   = 'h08;
    localparam int unsigned OFS_STATUS  = 'h0C;
    localparam int unsigned BIT_EN_BASE = 16;  // enable for status bit i sits at 16+i
    localparam int unsigned BIT_RESTART = 18;
    localparam int unsigned STS_ALARM   = 0;
    localparam int unsigned STS_INC     = 1;
    localparam int unsigned NUM_SRC     = 2;

    typedef enum logic {
        PS_STALL = 1'b0,
        PS_RUN   = 1'b1
    } ps_state_e;

    typedef enum logic [2:0] {
        RSEL_NONE,
        RSEL_MODE,
        RSEL_ALARM,
        RSEL_VALUE,
        RSEL_STATUS
    } reg_sel_e;
endpackage

// File: rtl/sectmr_decode.sv
module sectmr_decode
    import sectmr_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    always_comb begin
        unique case (addr)
            ADDR_W'(OFS_MODE):   sel = RSEL_MODE;
            ADDR_W'(OFS_ALARM):  sel = RSEL_ALARM;
            ADDR_W'(OFS_VALUE):  sel = RSEL_VALUE;
            ADDR_W'(OFS_STATUS): sel = RSEL_STATUS;
            default:             sel = RSEL_NONE;
        endcase
    end
endmodule

// File: rtl/sectmr_prescaler.sv
module sectmr_prescaler
    import sectmr_pkg::*;
#(
    parameter int unsigned PRE_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_tick,
    input  logic             restart,
    input  logic [PRE_W-1:0] prescale,
    output logic             inc
);
    ps_state_e        state_q, state_d;
    logic [PRE_W-1:0] pcnt_q, pcnt_d;
    logic [PRE_W:0]   pcnt_plus;
    logic             wrap;
    logic             running;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PS_STALL;
        else        state_q <= state_d;
    end

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_STALL: if (prescale != '0) state_d = PS_RUN;
            PS_RUN:   if (prescale == '0) state_d = PS_STALL;
            default:  state_d = PS_STALL;
        endcase
    end

    // outputs and phase update
    always_comb begin
        pcnt_plus = {1'b0, pcnt_q} + 1'b1;
        wrap      = (pcnt_plus >= {1'b0, prescale});
        running   = (state_q == PS_RUN) && (prescale != '0);
        inc       = running && slow_tick && !restart && wrap;
        if (restart || !running)
            pcnt_d = '0;
        else if (slow_tick)
            pcnt_d = wrap ? '0 : pcnt_plus[PRE_W-1:0];
        else
            pcnt_d = pcnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pcnt_q <= '0;
        else        pcnt_q <= pcnt_d;
    end

    // R3
    stall_no_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_STALL) |-> !inc);

    // R2
    phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> (pcnt_q == '0));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!slow_tick && !restart && state_q == PS_RUN && prescale != '0) |=> $stable(pcnt_q));
endmodule

// File: rtl/sectmr_counter.sv
module sectmr_counter #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             restart,
    input  logic [CNT_W-1:0] alarm,
    output logic [CNT_W-1:0] cnt,
    output logic             alarm_hit
);
    localparam logic [CNT_W-1:0] ALARM_OFF = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_next;

    always_comb begin
        cnt_next  = cnt_q + 1'b1;
        alarm_hit = inc && !restart && (alarm != ALARM_OFF) && (cnt_next == alarm);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (restart) cnt_q <= '0;
        else if (inc)     cnt_q <= cnt_next;
    end

    assign cnt = cnt_q;

    // R4
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0));

    // R2
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !restart) |=> (cnt == $past(cnt) + 1'b1));

    // R5
    no_write_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !restart) |=> $stable(cnt));
endmodule

// File: rtl/sectmr_regs.sv
module sectmr_regs
    import sectmr_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned PRE_W     = 16,
    parameter int unsigned CNT_W     = 32,
    parameter logic [PRE_W-1:0] PRE_RESET = 16'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              inc,
    input  logic              alarm_hit,
    output logic [PRE_W-1:0]  prescale,
    output logic              restart,
    output logic [CNT_W-1:0]  alarm,
    output logic              irq
);
    reg_sel_e           sel;
    logic               wr, rd, rd_status;
    logic [PRE_W-1:0]   presc_q;
    logic [NUM_SRC-1:0] en_q;
    logic [CNT_W-1:0]   alarm_q;
    logic [NUM_SRC-1:0] status_q, status_d, set_vec, irq_terms;
    logic [DATA_W-1:0]  mode_rd;

    sectmr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    assign wr        = bus_en && bus_we;
    assign rd        = bus_en && !bus_we;
    assign rd_status = rd && (sel == RSEL_STATUS);
    assign restart   = wr && (sel == RSEL_MODE) && bus_wdata[BIT_RESTART];

    assign set_vec[STS_ALARM] = alarm_hit;
    assign set_vec[STS_INC]   = inc;

    // per-source sticky flag with set winning over read-clear, and its irq term
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign status_d[i]  = set_vec[i] | (status_q[i] & ~rd_status);
        assign irq_terms[i] = status_q[i] & en_q[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            presc_q  <= PRE_RESET;
            en_q     <= '0;
            alarm_q  <= '1;
            status_q <= '0;
        end else begin
            status_q <= status_d;
            if (wr && sel == RSEL_MODE) begin
                presc_q <= bus_wdata[PRE_W-1:0];
                en_q    <= bus_wdata[BIT_EN_BASE +: NUM_SRC];
            end
            if (wr && sel == RSEL_ALARM)
                alarm_q <= bus_wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        mode_rd                          = '0;
        mode_rd[PRE_W-1:0]               = presc_q;
        mode_rd[BIT_EN_BASE +: NUM_SRC]  = en_q;
    end

    always_comb begin
        bus_rdata = '0;
        if (rd) begin
            unique case (sel)
                RSEL_MODE:   bus_rdata = mode_rd;
                RSEL_ALARM:  bus_rdata = DATA_W'(alarm_q);
                RSEL_VALUE:  bus_rdata = DATA_W'(cnt);
                RSEL_STATUS: bus_rdata = DATA_W'(status_q);
                default:     bus_rdata = '0;
            endcase
        end
    end

    assign prescale = presc_q;
    assign alarm    = alarm_q;
    assign irq      = |irq_terms;

    // R8
    read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && set_vec == '0) |=> (status_q == '0));

    // R8
    set_survives_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> status_q[STS_INC]);

    // R6
    alarm_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_q[STS_ALARM]) |-> ($past(alarm_q) != '1));

    // R9
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (status_q != '0) && (en_q != '0));

    // R4
    restart_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && sel == RSEL_MODE) |-> !bus_rdata[BIT_RESTART]);

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == RSEL_NONE) |-> (bus_rdata == '0));
endmodule

// File: rtl/sectmr_top.sv
module sectmr_top
    import sectmr_pkg::*;
#(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned PRE_W     = 16,
    parameter int unsigned CNT_W     = 32,
    parameter logic [PRE_W-1:0] PRE_RESET = 16'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    logic [PRE_W-1:0] prescale;
    logic             restart;
    logic             inc;
    logic [CNT_W-1:0] alarm;
    logic [CNT_W-1:0] cnt;
    logic             alarm_hit;

    sectmr_regs #(
        .ADDR_W    (ADDR_W),
        .PRE_W     (PRE_W),
        .CNT_W     (CNT_W),
        .PRE_RESET (PRE_RESET)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt       (cnt),
        .inc       (inc),
        .alarm_hit (alarm_hit),
        .prescale  (prescale),
        .restart   (restart),
        .alarm     (alarm),
        .irq       (irq)
    );

    sectmr_prescaler #(.PRE_W(PRE_W)) u_prescaler (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_tick (slow_tick),
        .restart   (restart),
        .prescale  (prescale),
        .inc       (inc)
    );

    sectmr_counter #(.CNT_W(CNT_W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc       (inc),
        .restart   (restart),
        .alarm     (alarm),
        .cnt       (cnt),
        .alarm_hit (alarm_hit)
    );
endmodule

// File: tb/sectmr_top_bench.sv
module sectmr_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    localparam logic [31:0] RST_BIT = 32'h0004_0000;
    localparam logic [31:0] AEN     = 32'h0001_0000;
    localparam logic [31:0] IEN     = 32'h0002_0000;

    always #5 clk = ~clk;

    sectmr_top u_sectmr_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_tick (slow_tick),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int t = 0; t < n; t++) begin
            @(negedge clk);
            slow_tick = 1'b1;
            @(negedge clk);
            slow_tick = 1'b0;
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(8'h00, v); check("R1 mode", v, 32'h0000_8000);
        bus_read(8'h04, v); check("R1 alarm", v, 32'hFFFF_FFFF);
        bus_read(8'h08, v); check("R1 value", v, 32'h0);
        bus_read(8'h0C, v); check("R1 status", v, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R2 sweep of prescaler values, counter read after every tick
        for (int n = 1; n <= 5; n++) begin
            bus_write(8'h00, 32'(n) | RST_BIT);
            bus_read(8'h08, v); check("R4 restart clears", v, 32'h0);
            for (int k = 1; k <= 3 * n; k++) begin
                ticks(1);
                bus_read(8'h08, v); check("R2 ticks/N", v, 32'(k / n));
            end
        end

        // R2 sparse ticks with idle gaps
        bus_write(8'h00, 32'd3 | RST_BIT);
        for (int t = 0; t < 7; t++) begin
            ticks(1);
            repeat (2) @(negedge clk);
        end
        bus_read(8'h08, v); check("R2 sparse", v, 32'd2);

        // R5 status write ignored, R7 inc flag, R6 no alarm at all-ones
        bus_write(8'h0C, 32'h0);
        bus_read(8'h0C, v); check("R5 R7 status after writes", v, 32'h2);
        bus_read(8'h0C, v); check("R8 read clears", v, 32'h0);
        // R5 counter write ignored
        bus_write(8'h08, 32'h0000_0055);
        bus_read(8'h08, v); check("R5 value write ignored", v, 32'd2);

        // R3 zero prescaler stalls
        bus_write(8'h00, 32'h0 | RST_BIT);
        ticks(6);
        bus_read(8'h08, v); check("R3 stalled value", v, 32'h0);
        bus_read(8'h0C, v); check("R3 no inc flag", v, 32'h0);

        // R4 restart bit reads zero, other fields kept
        bus_write(8'h00, 32'h0003_0005 | RST_BIT);
        bus_read(8'h00, v); check("R4 mode readback", v, 32'h0003_0005);

        // R6 alarm compare
        bus_write(8'h00, 32'd1 | RST_BIT);
        bus_write(8'h04, 32'd3);
        bus_read(8'h04, v); check("R6 alarm readback", v, 32'd3);
        bus_read(8'h0C, v);
        ticks(2);
        bus_read(8'h08, v); check("R2 value before alarm", v, 32'd2);
        bus_read(8'h0C, v); check("R6 no early alarm", v, 32'h2);
        ticks(1);
        bus_read(8'h08, v); check("R6 value at alarm", v, 32'd3);
        check("R9 irq masked", {31'b0, irq}, 32'h0);
        bus_write(8'h00, 32'd1 | AEN);
        check("R9 irq alarm enabled", {31'b0, irq}, 32'h1);
        bus_read(8'h0C, v); check("R6 alarm flag", v, 32'h3);
        check("R9 irq after clear", {31'b0, irq}, 32'h0);
        ticks(1);
        check("R9 inc only alarm enable", {31'b0, irq}, 32'h0);
        bus_write(8'h00, 32'd1 | IEN);
        check("R9 irq inc enabled", {31'b0, irq}, 32'h1);
        bus_read(8'h0C, v); check("R6 no refire past match", v, 32'h2);

        // R8 set in the same cycle as the read survives
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = 8'h0C; slow_tick = 1'b1;
        #1 v = bus_rdata;
        check("R8 old status on read", v, 32'h0);
        @(negedge clk);
        bus_en = 1'b0; slow_tick = 1'b0;
        check("R8 irq still set", {31'b0, irq}, 32'h1);
        bus_read(8'h0C, v); check("R8 flag survived", v, 32'h2);

        // R10 unmapped and unaligned
        bus_read(8'h10, v); check("R10 read 0x10", v, 32'h0);
        bus_read(8'h02, v); check("R10 read 0x02", v, 32'h0);
        bus_read(8'hFC, v); check("R10 read 0xFC", v, 32'h0);
        bus_write(8'h10, 32'hFFFF_FFFF);
        bus_write(8'h01, 32'hFFFF_FFFF);
        bus_read(8'h00, v); check("R10 mode untouched", v, 32'h0002_0001);
        bus_read(8'h04, v); check("R10 alarm untouched", v, 32'd3);

        finish_run();
    end
endmodule